// File: doc/BRIEF.md
# UART Register Front-End

This block is the processor-facing side of a serial port. A simple word-addressed CPU bus reaches three registers through it: transmit data, receive data and status. It sits between the bus and a byte-stream serial engine, with a valid/ready byte stream on each side. The bit-level shifter and baud logic lie outside the block.

Receive side: the block keeps one incoming byte in a holding slot and reports it through a receive-ready status flag. A new byte from the serial engine is taken only while the slot is empty. While the slot is full, the engine sees backpressure. Reading the receive register empties the slot. Transmit side: a bus write to the transmit register passes the low byte on as a single-cycle valid pulse, but only while the downstream is ready. Read data comes back one cycle after the read strobe, from a register.

Register layout (byte offsets, 32-bit accesses only): 0x00 transmit data (write), 0x04 receive data (read), 0x14 status (read). The window is 0x18 bytes long, and the word index is the byte address shifted right by two.

Top module: `uart_reg_frontend`

## Requirements
- R1: After reset, `bus_rdata` is 0, `rx_ready` is 1 and `tx_valid` is 0. A status read returns only bit 1 (transmit-ready, which follows `tx_ready`). A receive read returns 0.
- R2: A read at offset 0x14 returns a status word with bit 0 = receive-ready (a byte is held), bit 1 = the level of `tx_ready` in the strobe cycle, and all other bits 0.
- R3: `rx_ready` is the inverse of receive-ready. A byte is taken in a cycle where `rx_valid` and `rx_ready` are both 1. The byte is latched and receive-ready is 1 from the next cycle on.
- R4: A read at offset 0x04 returns the held byte in bits 7:0 with zeros above. It clears receive-ready at the clock edge that ends the strobe cycle, so `rx_ready` is 1 in the following cycle.
- R5: While receive-ready is 1, incoming bytes are refused (`rx_ready` = 0). The held byte is not overwritten.
- R6: If a receive read and an incoming byte meet in a cycle where the slot is full, the byte is not taken in that cycle. It is taken in the next cycle if still presented.
- R7: A write at offset 0x00 while `tx_ready` = 1 raises `tx_valid` for exactly that cycle, with `tx_data` = write data bits 7:0.
- R8: A transmit write while `tx_ready` = 0 is dropped: `tx_valid` stays 0.
- R9: Writes at offset 0x14 have no effect on the status or on the held byte.
- R10: `bus_rdata` changes only on the edge that ends a read-strobe cycle. It holds its value until the next strobe.
- R11: Reads of any other address return 0, and writes there are dropped. This covers addresses with nonzero bits 1:0, indices 6 and 7 past the window, offsets 0x08, 0x0C and 0x10, and a read at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (5) | Byte address of the access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Registered read data |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | BYTE_W (8) | Incoming byte |
| rx_ready | output | 1 | Holding slot empty, byte can be taken |
| tx_valid | output | 1 | Outgoing byte valid pulse |
| tx_data | output | BYTE_W (8) | Outgoing byte |
| tx_ready | input | 1 | Downstream can take a byte |

## Verification
The bench builds the block with its default parameters: a 5-bit address, 32-bit data and 8-bit bytes. With these, all 32 byte addresses can be swept for both reads and writes, so every aligned, unaligned and out-of-window case is visited. All 256 byte values go through the receive slot and through the transmit path, with `tx_ready` alternating between 1 and 0. Expected read words are built arithmetically from the address and from the byte pushed. Separate sequences cover the full-slot refusal and the collision between a read and an incoming byte.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TX   = 2'd1,
    SEL_RX   = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int unsigned ST_RXRDY_BIT = 0;
  localparam int unsigned ST_TXRDY_BIT = 1;

endpackage

// File: rtl/uart_fe_decode.sv
module uart_fe_decode
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned WIN_WORDS = 6,
  parameter int unsigned TX_IDX    = 0,
  parameter int unsigned RX_IDX    = 1,
  parameter int unsigned ST_IDX    = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_win;

  always_comb begin
    idx     = addr[ADDR_W-1:2];
    aligned = (addr[1:0] == 2'b00);
    in_win  = ({1'b0, idx} < (IDX_W+1)'(WIN_WORDS));
    sel     = SEL_NONE;
    if (aligned && in_win) begin
      if (idx == IDX_W'(TX_IDX))      sel = SEL_TX;
      else if (idx == IDX_W'(RX_IDX)) sel = SEL_RX;
      else if (idx == IDX_W'(ST_IDX)) sel = SEL_STAT;
    end
  end
endmodule

// File: rtl/uart_fe_rx_slot.sv
module uart_fe_rx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              drain,
  output logic [BYTE_W-1:0] held,
  output logic              full
);
  logic take;

  assign in_ready = ~full;
  assign take     = in_valid & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
      full <= 1'b0;
    end else begin
      if (take) begin
        held <= in_data;
        full <= 1'b1;
      end else if (drain) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_fe_tx_gate.sv
module uart_fe_tx_gate #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data
);
  assign out_valid = wr_hit & out_ready;
  assign out_data  = wbyte;
endmodule

// File: rtl/uart_fe_rdmux.sv
module uart_fe_rdmux
  import uart_fe_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] held,
  input  logic              full,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] next_word;

  always_comb begin
    stat_word               = '0;
    stat_word[ST_RXRDY_BIT] = full;
    stat_word[ST_TXRDY_BIT] = tx_ready;
    case (sel)
      SEL_RX:   next_word = DATA_W'(held);
      SEL_STAT: next_word = stat_word;
      default:  next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= next_word;
  end
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
  import uart_fe_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned WIN_WORDS = 6,
  parameter int unsigned TX_IDX    = 0,
  parameter int unsigned RX_IDX    = 1,
  parameter int unsigned ST_IDX    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd_en,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ready
);
  reg_sel_e          sel;
  logic              rd_rx;
  logic              wr_tx;
  logic [BYTE_W-1:0] held;
  logic              full;

  uart_fe_decode #(
    .ADDR_W(ADDR_W), .WIN_WORDS(WIN_WORDS),
    .TX_IDX(TX_IDX), .RX_IDX(RX_IDX), .ST_IDX(ST_IDX)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  assign rd_rx = bus_rd_en & (sel == SEL_RX);
  assign wr_tx = bus_wr_en & (sel == SEL_TX);

  uart_fe_rx_slot #(.BYTE_W(BYTE_W)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .in_valid(rx_valid),
    .in_data (rx_data),
    .in_ready(rx_ready),
    .drain   (rd_rx),
    .held    (held),
    .full    (full)
  );

  uart_fe_tx_gate #(.BYTE_W(BYTE_W)) u_tx (
    .wr_hit   (wr_tx),
    .wbyte    (bus_wdata[BYTE_W-1:0]),
    .out_ready(tx_ready),
    .out_valid(tx_valid),
    .out_data (tx_data)
  );

  uart_fe_rdmux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (bus_rd_en),
    .sel     (sel),
    .held    (held),
    .full    (full),
    .tx_ready(tx_ready),
    .rdata   (bus_rdata)
  );
endmodule

// File: rtl/uart_reg_frontend_chk.sv
module uart_reg_frontend_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_en,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd_en,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [BYTE_W-1:0] tx_data,
  input logic              tx_ready
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0) && rx_ready && !tx_valid);

  p_take_fills_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> !rx_ready);

  p_refill_needs_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!rx_ready && !bus_rd_en) |=> !rx_ready);

  p_tx_gated_r8: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_ready);

  p_tx_byte_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> bus_wr_en && (tx_data == bus_wdata[BYTE_W-1:0]));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rdata));
endmodule

bind uart_reg_frontend uart_reg_frontend_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
  .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/uart_reg_frontend_tb.sv
module uart_reg_frontend_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr_en = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_rd_en = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic              rx_valid = 1'b0;
  logic [BYTE_W-1:0] rx_data = '0;
  logic              rx_ready;
  logic              tx_valid;
  logic [BYTE_W-1:0] tx_data;
  logic              tx_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_reg_frontend u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end right after a falling edge.
  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    bus_addr = a; bus_rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd_en = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] w,
                           output logic tv, output logic [BYTE_W-1:0] td);
    bus_addr = a; bus_wdata = w; bus_wr_en = 1'b1;
    #1 tv = tx_valid; td = tx_data;
    @(posedge clk); @(negedge clk);
    bus_wr_en = 1'b0;
    #1;
  endtask

  task automatic push_byte(input logic [BYTE_W-1:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] stat_exp(input bit held, input bit txr);
    return {30'd0, txr, held};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic              tv;
    logic [BYTE_W-1:0] td;
    logic [31:0]       exp;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;

    // R1 reset state
    check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    check(rx_ready == 1'b1, "R1 rx_ready", {31'd0, rx_ready}, 1);
    check(tx_valid == 1'b0, "R1 tx_valid", {31'd0, tx_valid}, 0);
    bus_read(5'h14, d); check(d == stat_exp(0, 1), "R1 status", d, stat_exp(0, 1));
    bus_read(5'h04, d); check(d == 0, "R1 rx reg", d, 0);

    // R3 R4 R2: every byte value through the holding slot
    for (int v = 0; v < 256; v++) begin
      check(rx_ready == 1'b1, "R3 ready before push", {31'd0, rx_ready}, 1);
      push_byte(v[7:0]);
      check(rx_ready == 1'b0, "R3 ready after take", {31'd0, rx_ready}, 0);
      bus_read(5'h14, d); check(d == stat_exp(1, 1), "R2 status full", d, stat_exp(1, 1));
      bus_read(5'h04, d); check(d == {24'd0, v[7:0]}, "R4 rx data", d, {24'd0, v[7:0]});
      check(rx_ready == 1'b1, "R4 cleared", {31'd0, rx_ready}, 1);
    end

    // R5 full slot refuses bytes, held byte kept
    push_byte(8'h5A);
    rx_valid = 1'b1; rx_data = 8'hC3;
    for (int i = 0; i < 4; i++) begin
      #1 check(rx_ready == 1'b0, "R5 backpressure", {31'd0, rx_ready}, 0);
      @(posedge clk); @(negedge clk);
    end
    rx_valid = 1'b0;
    bus_read(5'h04, d); check(d == 32'h5A, "R5 held kept", d, 32'h5A);

    // R6 read and incoming byte collide while full
    push_byte(8'h11);
    bus_addr = 5'h04; bus_rd_en = 1'b1; rx_valid = 1'b1; rx_data = 8'h22;
    #1 check(rx_ready == 1'b0, "R6 not taken in strobe cycle", {31'd0, rx_ready}, 0);
    @(posedge clk); @(negedge clk);
    bus_rd_en = 1'b0;
    #1 check(bus_rdata == 32'h11, "R6 old byte read", bus_rdata, 32'h11);
    check(rx_ready == 1'b1, "R6 ready next cycle", {31'd0, rx_ready}, 1);
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; #1;
    check(rx_ready == 1'b0, "R6 taken next cycle", {31'd0, rx_ready}, 0);
    bus_read(5'h04, d); check(d == 32'h22, "R6 new byte", d, 32'h22);

    // R9 status writes ignored while full
    push_byte(8'h77);
    bus_write(5'h14, 32'hFFFF_FF00, tv, td);
    check(tv == 1'b0, "R9 no tx", {31'd0, tv}, 0);
    bus_read(5'h14, d); check(d == stat_exp(1, 1), "R9 status kept", d, stat_exp(1, 1));
    bus_write(5'h14, 32'h0, tv, td);
    bus_read(5'h14, d); check(d == stat_exp(1, 1), "R9 status kept 0", d, stat_exp(1, 1));
    bus_read(5'h04, d); check(d == 32'h77, "R9 held kept", d, 32'h77);

    // R7 R8 R2: every byte value on transmit, tx_ready alternating
    for (int v = 0; v < 256; v++) begin
      tx_ready = v[0];
      bus_write(5'h00, {24'hABCDEF, v[7:0]}, tv, td);
      check(tv == v[0], "R7/R8 tx_valid", {31'd0, tv}, {31'd0, v[0]});
      if (v[0]) check(td == v[7:0], "R7 tx_data", {24'd0, td}, {24'd0, v[7:0]});
      else check(tv == 1'b0, "R8 dropped", {31'd0, tv}, 0);
      check(tx_valid == 1'b0, "R7 single pulse", {31'd0, tx_valid}, 0);
      bus_read(5'h14, d); check(d == stat_exp(0, v[0]), "R2 tx bit", d, stat_exp(0, v[0]));
    end
    tx_ready = 1'b1;

    // R11 read sweep over all byte addresses; held byte is 0x77
    for (int a = 0; a < 32; a++) begin
      bus_read(a[4:0], d);
      exp = (a == 4) ? 32'h77 : (a == 20) ? stat_exp(0, 1) : 32'd0;
      check(d == exp, "R11 read sweep", d, exp);
    end

    // R11 R9 write sweep: only 0x00 forwards, nothing changes state
    for (int a = 0; a < 32; a++) begin
      bus_write(a[4:0], 32'hFFFF_FF3C, tv, td);
      check(tv == (a == 0), "R11 write sweep tx", {31'd0, tv}, {31'd0, a == 0});
      check(rx_ready == 1'b1, "R11 write sweep rx", {31'd0, rx_ready}, 1);
    end
    bus_read(5'h04, d); check(d == 32'h77, "R11 held after writes", d, 32'h77);

    // R10 read data holds between strobes
    bus_read(5'h14, d);
    push_byte(8'h99);
    for (int i = 0; i < 3; i++) begin
      check(bus_rdata == stat_exp(0, 1), "R10 hold", bus_rdata, stat_exp(0, 1));
      @(posedge clk); @(negedge clk); #1;
    end
    bus_read(5'h04, d); check(d == 32'h99, "R10 next strobe", d, 32'h99);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule